// File: doc/BRIEF.md
# Auto-Reload Down-Counter Timer

This block is a down-counter that steps once per time-base tick and flags an event on the tick that takes it from one to zero. The event sets a sticky status bit, and an interrupt enable passes that bit to the interrupt output. Software clears the status bit by writing one to it. A write of zero leaves it alone.

The counter, the reload value and a two-bit control field are each loaded through their own write strobe. With auto-reload on, the counter takes the reload value at the moment of the event, which makes the timer periodic. With auto-reload off, the counter parks at zero and stays silent until software loads it again.

Top module: `auto_reload_countdown`

## Requirements
- R1: Each clock with `tick` high and a nonzero count lowers `count` by one. Without `tick`, `count` holds.
- R2: An event occurs only on a tick that moves `count` from 1 to 0, and it sets `status` one clock later. A count already at zero raises no further event.
- R3: `irq` is high exactly when `status` is high and control bit 0 (interrupt enable) is set.
- R4: A clock with `stat_clr` high clears `status`. When `stat_clr` is low, `status` is unchanged.
- R5: A counter write (`cnt_we`) loads `cnt_wdata` and takes priority over a tick in the same clock.
- R6: With control bit 1 (auto-reload) clear, the counter stops at zero after an event.
- R7: With control bit 1 set, the counter loads the reload register at each event, so events repeat every reload-value ticks.
- R8: A reload value of zero with auto-reload on gives one event, after which the counter holds at zero with no further events.
- R9: When an event and `stat_clr` fall in the same clock, `status` ends up set.
- R10: Reset clears the count, the reload value, both control bits and `status`. The interrupt stays low until software sets the enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | W | Reload value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Bit 0 interrupt enable, bit 1 auto-reload |
| stat_clr | input | 1 | Write-one-to-clear strobe for status |
| count | output | W | Current counter value |
| status | output | 1 | Latched event status |
| irq | output | 1 | Interrupt output |

## Verification
The properties assume every strobe is a clean, synchronous level that is known in every clock after reset. They also assume that a reload write and an event do not fall in the same clock, because the reload property compares against the reload register's value before the edge.

The stimulus drives every input on the falling edge and returns each strobe to zero after one clock. It never writes the reload register in a clock where the count is one and a tick is present.

// File: rtl/auto_reload_countdown.sv
module auto_reload_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         ctrl_we,
  input  logic [1:0]   ctrl_wdata,
  input  logic         stat_clr,
  output logic [W-1:0] count,
  output logic         status,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q;
  logic [1:0]   ctrl_q;
  logic         fire;

  assign fire = tick && !cnt_we && (count == ONE);
  assign irq  = status && ctrl_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      status   <= 1'b0;
    end else begin
      if (cnt_we)
        count <= cnt_wdata;
      else if (fire)
        count <= ctrl_q[1] ? reload_q : '0;
      else if (tick && count != '0)
        count <= count - ONE;
      if (reload_we) reload_q <= reload_wdata;
      if (ctrl_we)   ctrl_q   <= ctrl_wdata;
      if (fire)
        status <= 1'b1;
      else if (stat_clr)
        status <= 1'b0;
    end
  end
endmodule

module auto_reload_countdown_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic [W-1:0] cnt_wdata,
  input logic         stat_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] reload_q,
  input logic [1:0]   ctrl_q,
  input logic         status,
  input logic         irq
);
  p_decrement_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count > W'(1)) |=> count == $past(count) - W'(1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == W'(1)) |=> status);
  p_irq_needs_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && ctrl_q[0]));
  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !stat_clr) |=> status);
  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));
  p_zero_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !cnt_we) |=> count == '0);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == W'(1) && ctrl_q[1]) |=> count == $past(reload_q));
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !(tick && count == W'(1))) |=> !status);
endmodule

bind auto_reload_countdown auto_reload_countdown_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .stat_clr(stat_clr), .count(count), .reload_q(reload_q), .ctrl_q(ctrl_q),
  .status(status), .irq(irq)
);

// File: tb/tb_auto_reload_countdown.sv
module tb_auto_reload_countdown;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         cnt_we = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic         reload_we = 1'b0;
  logic [W-1:0] reload_wdata = '0;
  logic         ctrl_we = 1'b0;
  logic [1:0]   ctrl_wdata = '0;
  logic         stat_clr = 1'b0;
  logic [W-1:0] count;
  logic         status;
  logic         irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  auto_reload_countdown #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .stat_clr(stat_clr), .count(count), .status(status),
    .irq(irq)
  );

  // load, ticks, expected count, expected status (auto-reload off)
  localparam int NV = 7;
  localparam logic [W-1:0] VEC [NV][4] = '{
    '{32'd5,          32'd3,  32'd2,          32'd0},
    '{32'd5,          32'd5,  32'd0,          32'd1},
    '{32'd5,          32'd9,  32'd0,          32'd1},
    '{32'd1,          32'd1,  32'd0,          32'd1},
    '{32'd100,        32'd40, 32'd60,         32'd0},
    '{32'd0,          32'd4,  32'd0,          32'd0},
    '{32'hFFFF_FFFF,  32'd2,  32'hFFFF_FFFD,  32'd0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
  endtask
  task automatic wr_reload(input logic [W-1:0] v);
    reload_we = 1'b1; reload_wdata = v; @(negedge clk); reload_we = 1'b0;
  endtask
  task automatic wr_ctrl(input logic [1:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic clr_stat();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask
  task automatic ticks(input int n);
    tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
  endtask
  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 count", count, '0);
    chk("R10 status", W'(status), '0);
    chk("R10 irq", W'(irq), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      clr_stat();
      wr_cnt(VEC[i][0]);
      ticks(int'(VEC[i][1]));
      chk("R1/R6 count", count, VEC[i][2]);
      chk("R2 status", W'(status), VEC[i][3]);
    end

    // R1: no tick, count holds
    clr_stat();
    wr_cnt(32'd7);
    repeat (3) @(negedge clk);
    chk("R1 hold", count, 32'd7);

    // R3: interrupt gating
    wr_cnt(32'd1);
    ticks(1);
    chk("R3 masked irq", W'(irq), '0);
    wr_ctrl(2'b01);
    chk("R3 enabled irq", W'(irq), 32'd1);
    // R4: status untouched without clear, cleared by clear
    @(negedge clk);
    chk("R4 sticky", W'(status), 32'd1);
    clr_stat();
    chk("R4 cleared", W'(status), '0);
    chk("R3 irq drops", W'(irq), '0);

    // R5: write beats tick
    wr_cnt(32'd10);
    tick = 1'b1; cnt_we = 1'b1; cnt_wdata = 32'd50;
    @(negedge clk);
    tick = 1'b0; cnt_we = 1'b0;
    chk("R5 write priority", count, 32'd50);

    // R7: periodic reload
    wr_reload(32'd4);
    wr_ctrl(2'b11);
    wr_cnt(32'd2);
    ticks(2);
    chk("R7 reload count", count, 32'd4);
    chk("R7 first event", W'(status), 32'd1);
    clr_stat();
    ticks(4);
    chk("R7 second reload", count, 32'd4);
    chk("R7 second event", W'(status), 32'd1);
    ticks(3);
    chk("R7 mid period", count, 32'd1);

    // R9: event beats clear
    tick = 1'b1; stat_clr = 1'b1;
    @(negedge clk);
    tick = 1'b0; stat_clr = 1'b0;
    chk("R9 event wins", W'(status), 32'd1);

    // R8: zero reload gives one event then holds
    clr_stat();
    wr_reload(32'd0);
    wr_cnt(32'd1);
    ticks(1);
    chk("R8 one event", W'(status), 32'd1);
    chk("R8 count zero", count, '0);
    clr_stat();
    ticks(5);
    chk("R8 no repeat", W'(status), '0);
    chk("R8 holds zero", count, '0);

    // R10: mid-run reset clears control and status
    wr_ctrl(2'b01);
    wr_cnt(32'd1);
    ticks(1);
    chk("R10 pre-reset irq", W'(irq), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 status cleared", W'(status), '0);
    chk("R10 count cleared", count, '0);
    wr_cnt(32'd1);
    ticks(1);
    chk("R10 enable cleared", W'(irq), '0);
    chk("R10 auto-reload cleared", count, '0);

    finish_run();
  end
endmodule